// File: doc/BRIEF.md
# Rotating Register File

This block is a register file for software-pipelined loops. Its logical register space has two regions. The low specifiers form a fixed region, and they always address the same physical entry. The high specifiers form a rotating region. Each rotating specifier is renamed by adding a rotation base held inside the block, and the sum wraps around the size of that region.

Each pass through the loop-closing branch pulses `loop_step`, which lowers the base by one. As a result, every iteration sees a fresh set of physical entries. A value that one iteration writes under logical register n is found by the next iteration under logical register n+1.

The file has two read ports and one write port. All three ports take logical specifiers. Reads are combinational. A write to the entry being read in the same cycle is forwarded to that read output. Software can also overwrite the base directly through `base_load`.

Top module: `rotreg_file`

## Requirements
- R1: After reset the rotation base is 0 and every read port returns 0 for every specifier.
- R2: A specifier below NUM_STATIC (default 8) addresses the same physical entry whatever the rotation base is.
- R3: A specifier s with NUM_STATIC <= s < NUM_STATIC+NUM_ROT addresses physical entry NUM_STATIC + ((s - NUM_STATIC + base) mod NUM_ROT), with NUM_ROT defaulting to 16.
- R4: Each cycle with `loop_step` high and `base_load` low lowers the base by one, and a base of 0 becomes NUM_ROT-1. With neither input high, the base holds.
- R5: `base_load` writes `base_value` into the base at the next edge. When `base_load` and `loop_step` are both high, the load wins.
- R6: A value written under logical specifier n, followed by one step, is read back under specifier n+1.
- R7: When `wr_en` is high and a read specifier maps to the same physical entry as the write specifier, that read port returns `wr_data` in the same cycle.
- R8: Reads and the write in a cycle that also steps or loads the base all use the base from before that cycle's edge.
- R9: The two read ports decode their specifiers independently of each other.
- R10: With `wr_en` low, no entry changes. With `wr_en` high, the mapped entry holds `wr_data` after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_spec | input | SPEC_W | Logical specifier for read port 0 |
| rd0_data | output | DATA_W | Read port 0 data |
| rd1_spec | input | SPEC_W | Logical specifier for read port 1 |
| rd1_data | output | DATA_W | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_spec | input | SPEC_W | Logical specifier for the write |
| wr_data | input | DATA_W | Write data |
| loop_step | input | 1 | Loop-closing branch taken: lower the base by one |
| base_load | input | 1 | Load the base directly |
| base_value | input | ROT_W | Value to load; must be below NUM_ROT |
| base_out | output | ROT_W | Current rotation base |

## Verification
The hardest situation to reach combines three things in one cycle: the base wraps, the rotating sum crosses the top of its region, and a write is forwarded. All of this has to happen while the base is also changing.

The stimulus uses `base_load` to move the base straight to 0 and to NUM_ROT-1. It then steps and writes in the same cycle, and reads the highest rotating specifier. A twenty-iteration loop writes specifier 8 and reads specifier 9 on every step. This loop walks the base through its whole wrap and checks the hand-off from one iteration to the next.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

   // index width that stays at least one bit for tiny counts
   function automatic int idx_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl #(
   parameter int NUM_ROT = 16,
   localparam int ROT_W = rrf_pkg::idx_w(NUM_ROT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             load_i,
   input  logic [ROT_W-1:0] load_val_i,
   output logic [ROT_W-1:0] base_o
);

   localparam logic [ROT_W-1:0] TOP = ROT_W'(NUM_ROT - 1);

   logic [ROT_W-1:0] base_q;
   logic [ROT_W-1:0] base_d;
   logic [ROT_W-1:0] base_dec;

   assign base_dec = (base_q == '0) ? TOP : base_q - 1'b1;

   always_comb begin
      base_d = base_q;
      if (load_i)
         base_d = load_val_i;
      else if (step_i)
         base_d = base_dec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         base_q <= '0;
      else
         base_q <= base_d;
   end

   assign base_o = base_q;

   AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (base_q == (($past(base_q) == '0) ? TOP : $past(base_q) - 1'b1))); // R4
   AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(base_q)); // R4
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (base_q == $past(load_val_i))); // R5
   AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (load_val_i <= TOP)); // R5
   AST_BASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      base_q <= TOP); // R3

endmodule

// File: rtl/rrf_remap.sv
module rrf_remap #(
   parameter int NUM_STATIC = 8,
   parameter int NUM_ROT    = 16,
   localparam int TOTAL  = NUM_STATIC + NUM_ROT,
   localparam int SPEC_W = rrf_pkg::idx_w(TOTAL),
   localparam int ROT_W  = rrf_pkg::idx_w(NUM_ROT)
) (
   input  logic [SPEC_W-1:0] spec_i,
   input  logic [ROT_W-1:0]  base_i,
   output logic [SPEC_W-1:0] phys_o
);

   logic [ROT_W-1:0] off;
   logic [ROT_W:0]   sum;
   logic [ROT_W-1:0] wrapped;
   logic             is_rot;

   generate
      if (NUM_STATIC == 0) begin : g_all_rot
         assign is_rot = 1'b1;
         assign off    = ROT_W'(spec_i);
      end else begin : g_split
         assign is_rot = (spec_i >= SPEC_W'(NUM_STATIC));
         assign off    = ROT_W'(spec_i - SPEC_W'(NUM_STATIC));
      end
   endgenerate

   assign sum = {1'b0, off} + {1'b0, base_i};

   generate
      if (rrf_pkg::is_pow2(NUM_ROT)) begin : g_mask_wrap
         assign wrapped = sum[ROT_W-1:0];
      end else begin : g_sub_wrap
         assign wrapped = (sum >= (ROT_W+1)'(NUM_ROT)) ?
                          ROT_W'(sum - (ROT_W+1)'(NUM_ROT)) : sum[ROT_W-1:0];
      end
   endgenerate

   assign phys_o = is_rot ? (SPEC_W'(NUM_STATIC) + SPEC_W'(wrapped)) : spec_i;

endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
   parameter int DATA_W  = 32,
   parameter int ENTRIES = 24,
   parameter int NUM_RD  = 2,
   parameter bit BYPASS  = 1'b1,
   localparam int IDX_W  = rrf_pkg::idx_w(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en_i,
   input  logic [IDX_W-1:0]              wr_idx_i,
   input  logic [DATA_W-1:0]             wr_data_i,
   input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx_i,
   output logic [NUM_RD-1:0][DATA_W-1:0] rd_data_o
);

   logic [DATA_W-1:0] mem [ENTRIES];
   logic              wr_ok;

   assign wr_ok = wr_en_i && (wr_idx_i < IDX_W'(ENTRIES));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++)
            mem[i] <= '0;
      end else if (wr_ok) begin
         mem[wr_idx_i] <= wr_data_i;
      end
   end

   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
         logic [DATA_W-1:0] raw;
         assign raw = (rd_idx_i[p] < IDX_W'(ENTRIES)) ? mem[rd_idx_i[p]] : '0;
         if (BYPASS) begin : g_fwd
            assign rd_data_o[p] = (wr_ok && (wr_idx_i == rd_idx_i[p])) ? wr_data_i : raw;
         end else begin : g_plain
            assign rd_data_o[p] = raw;
         end
      end
   endgenerate

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> (mem[$past(wr_idx_i)] == $past(wr_data_i))); // R10
   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && $past(rst_n)) |=> (mem[$past(rd_idx_i[0])] == $past(rd_data_o[0])
                                      || $past(rd_idx_i[0]) >= IDX_W'(ENTRIES))); // R10

endmodule

// File: rtl/rotreg_file.sv
module rotreg_file #(
   parameter int DATA_W       = 32,
   parameter int NUM_STATIC   = 8,
   parameter int NUM_ROT      = 16,
   parameter bit WRITE_BYPASS = 1'b1,
   localparam int TOTAL  = NUM_STATIC + NUM_ROT,
   localparam int SPEC_W = rrf_pkg::idx_w(TOTAL),
   localparam int ROT_W  = rrf_pkg::idx_w(NUM_ROT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SPEC_W-1:0] rd0_spec,
   output logic [DATA_W-1:0] rd0_data,
   input  logic [SPEC_W-1:0] rd1_spec,
   output logic [DATA_W-1:0] rd1_data,
   input  logic              wr_en,
   input  logic [SPEC_W-1:0] wr_spec,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              loop_step,
   input  logic              base_load,
   input  logic [ROT_W-1:0]  base_value,
   output logic [ROT_W-1:0]  base_out
);

   localparam int NPORT = 3;  // two reads, then the write

   generate
      if (NUM_ROT < 2) begin : g_bad_rot
         $error("rotreg_file: NUM_ROT must be at least 2");
      end
      if (NUM_STATIC < 0) begin : g_bad_static
         $error("rotreg_file: NUM_STATIC must not be negative");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rotreg_file: DATA_W must be positive");
      end
   endgenerate

   logic [ROT_W-1:0]             base;
   logic [NPORT-1:0][SPEC_W-1:0] spec_all;
   logic [NPORT-1:0][SPEC_W-1:0] phys_all;
   logic [1:0][SPEC_W-1:0]       rd_phys;
   logic [1:0][DATA_W-1:0]       rd_data;

   assign spec_all[0] = rd0_spec;
   assign spec_all[1] = rd1_spec;
   assign spec_all[2] = wr_spec;

   rrf_base_ctrl #(.NUM_ROT(NUM_ROT)) u_base (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (loop_step),
      .load_i     (base_load),
      .load_val_i (base_value),
      .base_o     (base)
   );

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_map
         rrf_remap #(.NUM_STATIC(NUM_STATIC), .NUM_ROT(NUM_ROT)) u_map (
            .spec_i (spec_all[p]),
            .base_i (base),
            .phys_o (phys_all[p])
         );
      end
   endgenerate

   assign rd_phys[0] = phys_all[0];
   assign rd_phys[1] = phys_all[1];

   rrf_storage #(
      .DATA_W  (DATA_W),
      .ENTRIES (TOTAL),
      .NUM_RD  (2),
      .BYPASS  (WRITE_BYPASS)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (phys_all[2]),
      .wr_data_i (wr_data),
      .rd_idx_i  (rd_phys),
      .rd_data_o (rd_data)
   );

   assign rd0_data = rd_data[0];
   assign rd1_data = rd_data[1];
   assign base_out = base;

   AST_STATIC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_spec < SPEC_W'(TOTAL) && rd0_spec >= SPEC_W'(NUM_STATIC)) || (phys_all[0] == rd0_spec)); // R2
   AST_ROT_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_spec >= SPEC_W'(NUM_STATIC) && wr_spec < SPEC_W'(TOTAL)) |->
      (phys_all[2] >= SPEC_W'(NUM_STATIC) && phys_all[2] < SPEC_W'(TOTAL))); // R3
   AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_step && !base_load && wr_spec >= SPEC_W'(NUM_STATIC) && wr_spec < SPEC_W'(TOTAL-1))
      |=> (phys_all[2] == $past(phys_all[2]) || wr_spec != $past(wr_spec) + 1'b1)); // R6
   AST_SAME_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_spec == rd1_spec) |-> (rd0_data == rd1_data)); // R9

endmodule

// File: tb/rotreg_file_test.sv
module rotreg_file_test;

   localparam int DW = 32;
   localparam int NS = 8;
   localparam int NR = 16;
   localparam int TOT = NS + NR;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [4:0]    rd0_spec, rd1_spec, wr_spec;
   logic [DW-1:0] rd0_data, rd1_data, wr_data;
   logic          wr_en, loop_step, base_load;
   logic [3:0]    base_value, base_out;

   always #2 clk = ~clk;

   rotreg_file uut (
      .clk(clk), .rst_n(rst_n),
      .rd0_spec(rd0_spec), .rd0_data(rd0_data),
      .rd1_spec(rd1_spec), .rd1_data(rd1_data),
      .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
      .loop_step(loop_step), .base_load(base_load),
      .base_value(base_value), .base_out(base_out)
   );

   typedef struct {
      string         tag;
      logic [DW-1:0] e0;
      logic [DW-1:0] e1;
      logic [3:0]    eb;
   } exp_t;

   exp_t          sb[$];
   event          ev_pushed;
   int            compared = 0;
   int            mismatched = 0;
   bit            finished = 1'b0;
   logic [DW-1:0] mdl [TOT];
   int            mbase = 0;

   function automatic int phys(input int s, input int b);
      if (s < NS) return s;
      return NS + ((s - NS + b) % NR);
   endfunction

   task automatic cyc(input string tag, input int r0, input int r1,
                      input bit we, input int ws, input logic [DW-1:0] wd,
                      input bit st, input bit ld, input int lv);
      exp_t e;
      @(negedge clk);
      rd0_spec = 5'(r0); rd1_spec = 5'(r1);
      wr_en = we; wr_spec = 5'(ws); wr_data = wd;
      loop_step = st; base_load = ld; base_value = 4'(lv);
      e.tag = tag;
      e.e0  = (we && phys(ws, mbase) == phys(r0, mbase)) ? wd : mdl[phys(r0, mbase)];
      e.e1  = (we && phys(ws, mbase) == phys(r1, mbase)) ? wd : mdl[phys(r1, mbase)];
      e.eb  = 4'(mbase);
      sb.push_back(e);
      ->ev_pushed;
      if (we) mdl[phys(ws, mbase)] = wd;
      if (ld) mbase = lv;
      else if (st) mbase = (mbase == 0) ? NR - 1 : mbase - 1;
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(ev_pushed);
         #1;
         e = sb.pop_front();
         compared++;
         if (rd0_data !== e.e0 || rd1_data !== e.e1 || base_out !== e.eb) begin
            mismatched++;
            $display("FAIL %s: rd0=%h rd1=%h base=%0d expected rd0=%h rd1=%h base=%0d",
                     e.tag, rd0_data, rd1_data, base_out, e.e0, e.e1, e.eb);
         end
      end
   end

   initial begin : watchdog
      #(200000 * 4);
      if (!finished) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : stimulus
      for (int i = 0; i < TOT; i++) mdl[i] = '0;
      rst_n = 1'b0; rd0_spec = '0; rd1_spec = '0; wr_en = 1'b0; wr_spec = '0;
      wr_data = '0; loop_step = 1'b0; base_load = 1'b0; base_value = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents and base
      cyc("R1", 0, 23, 0, 0, 0, 0, 0, 0);
      cyc("R1", 8, 15, 0, 0, 0, 0, 0, 0);
      // R2: fixed region ignores the base
      cyc("R2", 3, 0, 1, 3, 32'hA5A5_0003, 0, 0, 0);
      cyc("R5", 0, 0, 0, 0, 0, 0, 1, 5);
      cyc("R2", 3, 3, 0, 0, 0, 0, 0, 0);
      // R3: rotating map, base 8 then 9
      cyc("R5", 0, 0, 0, 0, 0, 0, 1, 8);
      cyc("R3", 9, 0, 1, 9, 32'h1111_0009, 0, 0, 0);
      cyc("R5", 0, 0, 0, 0, 0, 0, 1, 9);
      cyc("R3", 8, 9, 0, 0, 0, 0, 0, 0);
      // R3: sum wraps past top of rotating region
      cyc("R5", 0, 0, 0, 0, 0, 0, 1, 15);
      cyc("R3", 23, 8, 1, 23, 32'h5555_0017, 0, 0, 0);
      cyc("R5", 0, 0, 0, 0, 0, 0, 1, 14);
      cyc("R3", 8, 23, 0, 0, 0, 0, 0, 0);
      // R4: step down and wrap from 0
      cyc("R4", 0, 0, 0, 0, 0, 1, 0, 0);
      cyc("R5", 0, 0, 0, 0, 0, 0, 1, 0);
      cyc("R4", 0, 0, 0, 0, 0, 1, 0, 0);
      cyc("R4", 0, 0, 0, 0, 0, 0, 0, 0);
      // R5: load beats step
      cyc("R5", 0, 0, 0, 0, 0, 1, 1, 6);
      cyc("R5", 0, 0, 0, 0, 0, 0, 0, 0);
      // R8: write and step share a cycle, old base used
      cyc("R8", 10, 0, 1, 10, 32'h2222_000A, 1, 0, 0);
      cyc("R8", 11, 10, 0, 0, 0, 0, 0, 0);
      // R6: iteration hand-off across a full wrap of the base
      for (int i = 0; i < 20; i++)
         cyc("R6", 9, 8, 1, 8, 32'h0000_0100 + DW'(i), 1, 0, 0);
      // R7: same-cycle forwarding on both ports
      cyc("R7", 12, 2, 1, 12, 32'h3333_000C, 0, 0, 0);
      cyc("R7", 0, 2, 1, 2, 32'h4444_0002, 0, 0, 0);
      // R10: disabled write leaves storage alone
      cyc("R10", 12, 2, 0, 12, 32'hDEAD_BEEF, 0, 0, 0);
      cyc("R10", 12, 2, 0, 0, 0, 0, 0, 0);
      // R9: independent decode on both ports
      cyc("R9", 2, 12, 0, 0, 0, 0, 0, 0);
      cyc("R9", 3, 11, 0, 0, 0, 0, 0, 0);

      @(negedge clk);
      #2;
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule